// File: doc/BRIEF.md
# Host Parallel Port Handshake Interface

This block connects a processor-side byte register interface to an external host over a parallel port of up to three bytes. The port can run in either direction. To send data to the host, the processor loads the byte latches and the host then turns on the output drivers. To take data from the host, the host strobes a value into the latches and the processor then reads it out. In a multi-byte transfer, byte 0 is the commit byte. Only a processor access to byte 0 arms the handshake.

Two flags carry the handshake. The ready flag means the processor has loaded data for the host. The empty flag means the processor has taken the last host value. Each flag is shown on an external pin and as a processor status bit. The pin and the status bit always have opposite sense, and a polarity bit chooses which one is active high. A completed host transaction sends a one-cycle interrupt pulse to the processor.

The host control inputs are asynchronous. Each one is synchronized into the processor clock domain before any edge is detected.

Top module: `hostpar_port`

## Requirements
- R1: After reset, ready_pin is 0, empty_pin is 1, both polarity bits are 0, port_drive is 0 and port_irq is 0.
- R2: A processor write to byte 0 arms the ready flag. Writes to bytes 1 and 2 change no flag, and reads of bytes 1 and 2 change no flag.
- R3: The ready flag clears within three clocks after host_oe_n and host_cs_n are both low. It stays clear while they remain low.
- R4: A processor read of byte 0 arms the empty flag. The empty flag clears within three clocks after host_stb_n and host_cs_n are both low.
- R5: port_drive is 1 exactly while host_oe_n and host_cs_n are both low, after a three-clock synchronizing delay. While port_drive is 1, port_dout shows the latches, with byte k at bits [8k+7:8k].
- R6: A falling edge of host_stb_n with host_cs_n low captures port_din into all byte latches. Processor reads of bytes 0, 1 and 2 (cpu_addr 0, 1, 2) then return the captured bytes. A processor write to byte k replaces latch k.
- R7: A rising edge of host_oe_n or of host_stb_n while host_cs_n is low produces exactly one port_irq pulse, one clock wide.
- R8: While host_cs_n is high, host_stb_n and host_oe_n have no effect. There is no capture, no flag change, no drive and no interrupt.
- R9: ready_pin is the ready flag XOR the ready polarity bit, and empty_pin is the empty flag XOR the empty polarity bit. Each status bit is the inverse of its pin.
- R10: If a processor arm and a host clear of the same flag fall in the same cycle, the arm wins for that cycle. The flag clears on the next cycle if the host is still active.
- R11: cpu_rdata is registered and valid one clock after cpu_rd. Address 3 is the control register, with bit 0 the ready status bit, bit 1 the empty status bit, bit 2 the ready polarity (read/write) and bit 3 the empty polarity (read/write). All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 2 | Byte select 0..2, or 3 for the control register |
| cpu_wr | input | 1 | Processor write strobe, one cycle |
| cpu_rd | input | 1 | Processor read strobe, one cycle |
| cpu_wdata | input | 8 | Processor write data |
| cpu_rdata | output | 8 | Registered read data |
| host_stb_n | input | 1 | Host strobe, active low, asynchronous |
| host_oe_n | input | 1 | Host output enable, active low, asynchronous |
| host_cs_n | input | 1 | Host select, active low; gates strobe and output enable |
| port_din | input | 24 | Data from the port pads |
| port_dout | output | 24 | Latched data to the port pads |
| port_drive | output | 1 | Pad output enable |
| ready_pin | output | 1 | Ready flag pin, sense set by the polarity bit |
| empty_pin | output | 1 | Empty flag pin, sense set by the polarity bit |
| port_irq | output | 1 | One-cycle pulse when a host transaction ends |

## Verification
Random sequences mix processor byte accesses, host strobe and output-enable cycles, and polarity changes. A reference model predicts the pins, the status bits, the latch contents and the interrupt count. Host cycles run with host_cs_n both low and high, which separates the gating of capture, drive and interrupt. Accesses to bytes 1 and 2 alone show that only the commit byte arms the handshake. Directed cases hold the host active while the processor arms a flag, which separates arm-wins from clear-wins and separates level clearing from edge clearing.

// File: rtl/hpp_pkg.sv
`timescale 1ns/1ps
package hpp_pkg;
  localparam logic [1:0] CTRL_ADDR = 2'd3;
  localparam int CTRL_RDY_STAT = 0;
  localparam int CTRL_EMP_STAT = 1;
  localparam int CTRL_RDY_POL  = 2;
  localparam int CTRL_EMP_POL  = 3;
  localparam int CTRL_USED     = 4;

  typedef struct packed {
    logic emp_pol;
    logic rdy_pol;
  } hpp_pol_t;
endpackage

// File: rtl/hpp_sync.sv
`timescale 1ns/1ps
module hpp_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/hpp_host_events.sv
`timescale 1ns/1ps
module hpp_host_events (
  input  logic clk,
  input  logic rst,
  input  logic stb_s,
  input  logic oe_s,
  input  logic cs_s,
  output logic stb_act,
  output logic stb_fall,
  output logic stb_rise,
  output logic oe_act,
  output logic oe_rise
);
  logic stb_p, oe_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      stb_p <= 1'b1;
      oe_p  <= 1'b1;
    end else begin
      stb_p <= stb_s;
      oe_p  <= oe_s;
    end
  end

  // chip select gates every host event
  assign stb_act  = ~stb_s & ~cs_s;
  assign oe_act   = ~oe_s & ~cs_s;
  assign stb_fall = stb_p & ~stb_s & ~cs_s;
  assign stb_rise = ~stb_p & stb_s & ~cs_s;
  assign oe_rise  = ~oe_p & oe_s & ~cs_s;

  AST_OE_RISE_SPACED: assert property (@(posedge clk) disable iff (rst)
    oe_rise |=> !oe_rise); // R7
  AST_STB_RISE_SPACED: assert property (@(posedge clk) disable iff (rst)
    stb_rise |=> !stb_rise); // R7
endmodule

// File: rtl/hpp_latch_bank.sv
`timescale 1ns/1ps
module hpp_latch_bank #(
  parameter int NB = 3,
  parameter int BW = 8,
  localparam int DW = NB * BW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cpu_wr,
  input  logic [1:0]    cpu_addr,
  input  logic [BW-1:0] cpu_wdata,
  input  logic          cap_en,
  input  logic [DW-1:0] cap_data,
  output logic [DW-1:0] lat_out
);
  for (genvar g = 0; g < NB; g++) begin : g_byte
    logic [BW-1:0] lat_q;
    always_ff @(posedge clk) begin
      if (rst)
        lat_q <= '0;
      else if (cap_en)
        lat_q <= cap_data[g*BW +: BW];
      else if (cpu_wr && cpu_addr == 2'(g))
        lat_q <= cpu_wdata;
    end
    assign lat_out[g*BW +: BW] = lat_q;
  end
endmodule

// File: rtl/hpp_handshake.sv
`timescale 1ns/1ps
module hpp_handshake (
  input  logic clk,
  input  logic rst,
  input  logic arm_ready,
  input  logic arm_empty,
  input  logic oe_act,
  input  logic stb_act,
  input  logic oe_rise,
  input  logic stb_rise,
  output logic ready_q,
  output logic empty_q,
  output logic irq_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q <= 1'b0;
      empty_q <= 1'b1;
      irq_q   <= 1'b0;
    end else begin
      if (arm_ready)   ready_q <= 1'b1;
      else if (oe_act) ready_q <= 1'b0;
      if (arm_empty)    empty_q <= 1'b1;
      else if (stb_act) empty_q <= 1'b0;
      irq_q <= oe_rise | stb_rise;
    end
  end

  AST_READY_ARM: assert property (@(posedge clk) disable iff (rst)
    arm_ready |=> ready_q); // R2
  AST_EMPTY_ARM: assert property (@(posedge clk) disable iff (rst)
    arm_empty |=> empty_q); // R4
  AST_READY_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (oe_act && !arm_ready) |=> !ready_q); // R3
  AST_EMPTY_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (stb_act && !arm_empty) |=> !empty_q); // R4
endmodule

// File: rtl/hostpar_port.sv
`timescale 1ns/1ps
module hostpar_port #(
  parameter int NB = 3,
  parameter int BW = 8,
  parameter int SYNC_STAGES = 2,
  localparam int DW = NB * BW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    cpu_addr,
  input  logic          cpu_wr,
  input  logic          cpu_rd,
  input  logic [BW-1:0] cpu_wdata,
  output logic [BW-1:0] cpu_rdata,
  input  logic          host_stb_n,
  input  logic          host_oe_n,
  input  logic          host_cs_n,
  input  logic [DW-1:0] port_din,
  output logic [DW-1:0] port_dout,
  output logic          port_drive,
  output logic          ready_pin,
  output logic          empty_pin,
  output logic          port_irq
);
  import hpp_pkg::*;

  logic [2:0]    ctl_s;
  logic [DW-1:0] din_s;
  logic stb_act, stb_fall, stb_rise, oe_act, oe_rise;
  logic ready_q, empty_q, irq_q;
  logic drive_q;
  logic [BW-1:0] rdata_q;
  hpp_pol_t pol_q;
  logic arm_ready, arm_empty, ctrl_wr;
  logic rdy_bit, emp_bit;
  logic [BW-1:0] rd_mux;

  hpp_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_ctl_sync (
    .clk(clk), .rst(rst), .d({host_cs_n, host_oe_n, host_stb_n}), .q(ctl_s));

  // data follows the same depth so it lines up with the strobe edge
  hpp_sync #(.W(DW), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_dat_sync (
    .clk(clk), .rst(rst), .d(port_din), .q(din_s));

  hpp_host_events u_evt (
    .clk(clk), .rst(rst), .stb_s(ctl_s[0]), .oe_s(ctl_s[1]), .cs_s(ctl_s[2]),
    .stb_act(stb_act), .stb_fall(stb_fall), .stb_rise(stb_rise),
    .oe_act(oe_act), .oe_rise(oe_rise));

  hpp_latch_bank #(.NB(NB), .BW(BW)) u_lat (
    .clk(clk), .rst(rst), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cap_en(stb_fall), .cap_data(din_s),
    .lat_out(port_dout));

  assign arm_ready = cpu_wr && cpu_addr == 2'd0;
  assign arm_empty = cpu_rd && cpu_addr == 2'd0;
  assign ctrl_wr   = cpu_wr && cpu_addr == CTRL_ADDR;

  hpp_handshake u_hs (
    .clk(clk), .rst(rst), .arm_ready(arm_ready), .arm_empty(arm_empty),
    .oe_act(oe_act), .stb_act(stb_act), .oe_rise(oe_rise), .stb_rise(stb_rise),
    .ready_q(ready_q), .empty_q(empty_q), .irq_q(irq_q));

  assign ready_pin = ready_q ^ pol_q.rdy_pol;
  assign empty_pin = empty_q ^ pol_q.emp_pol;
  assign rdy_bit   = ~ready_pin;
  assign emp_bit   = ~empty_pin;

  always_comb begin
    rd_mux = '0;
    if (cpu_addr == CTRL_ADDR) begin
      rd_mux[CTRL_RDY_STAT] = rdy_bit;
      rd_mux[CTRL_EMP_STAT] = emp_bit;
      rd_mux[CTRL_RDY_POL]  = pol_q.rdy_pol;
      rd_mux[CTRL_EMP_POL]  = pol_q.emp_pol;
    end else begin
      for (int i = 0; i < NB; i++)
        if (cpu_addr == 2'(i)) rd_mux = port_dout[i*BW +: BW];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pol_q   <= '0;
      drive_q <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (ctrl_wr) begin
        pol_q.rdy_pol <= cpu_wdata[CTRL_RDY_POL];
        pol_q.emp_pol <= cpu_wdata[CTRL_EMP_POL];
      end
      drive_q <= oe_act;
      if (cpu_rd) rdata_q <= rd_mux;
    end
  end

  assign port_drive = drive_q;
  assign cpu_rdata  = rdata_q;
  assign port_irq   = irq_q;

  AST_SIDE_BYTE_NOFLAG: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && cpu_addr != 2'd0 && !oe_act) |=> $stable(ready_q)); // R2
  AST_DRIVE_NEEDS_SEL: assert property (@(posedge clk) disable iff (rst)
    (ctl_s[2] && !rst) |=> !port_drive); // R8
endmodule

// File: tb/hostpar_port_tb.sv
`timescale 1ns/1ps
module hostpar_port_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] cpu_addr = '0;
  logic cpu_wr = 1'b0, cpu_rd = 1'b0;
  logic [7:0] cpu_wdata = '0;
  logic [7:0] cpu_rdata;
  logic host_stb_n = 1'b1, host_oe_n = 1'b1, host_cs_n = 1'b1;
  logic [23:0] port_din = '0;
  logic [23:0] port_dout;
  logic port_drive, ready_pin, empty_pin, port_irq;

  int checks = 0, errors = 0, irq_seen = 0, exp_irq = 0;
  logic exp_ready, exp_empty, prdy, pemp;
  logic [7:0] exp_lat [3];

  always #10 clk = ~clk;

  hostpar_port dut_i (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .host_stb_n(host_stb_n),
    .host_oe_n(host_oe_n), .host_cs_n(host_cs_n), .port_din(port_din),
    .port_dout(port_dout), .port_drive(port_drive), .ready_pin(ready_pin),
    .empty_pin(empty_pin), .port_irq(port_irq));

  always @(posedge clk) if (!rst && port_irq === 1'b1) irq_seen++;

  function automatic logic [3:0] exp_ctrl();
    return {pemp, prdy, ~(exp_empty ^ pemp), ~(exp_ready ^ prdy)};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cpu_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
    if (a != 2'd3) exp_lat[a] = d;
    if (a == 2'd0) exp_ready = 1'b1;
    if (a == 2'd3) begin prdy = d[2]; pemp = d[3]; end
  endtask

  task automatic cpu_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_rd = 1'b1;
    @(negedge clk);
    cpu_rd = 1'b0;
    d = cpu_rdata;
    if (a == 2'd0) exp_empty = 1'b1;
  endtask

  task automatic check_state(input string tag);
    logic [7:0] r;
    chk({tag, " R9 ready_pin"}, ready_pin, exp_ready ^ prdy);
    chk({tag, " R9 empty_pin"}, empty_pin, exp_empty ^ pemp);
    cpu_read(2'd3, r);
    chk({tag, " R11 ctrl"}, r, {4'h0, exp_ctrl()});
    chk({tag, " R7 irq count"}, irq_seen, exp_irq);
  endtask

  task automatic host_write(input logic [23:0] d, input logic sel);
    @(negedge clk);
    port_din = d; host_cs_n = ~sel; host_stb_n = 1'b0;
    idle(4);
    chk("R8 no drive during strobe", port_drive, 1'b0);
    host_stb_n = 1'b1;
    idle(4);
    host_cs_n = 1'b1;
    idle(3);
    if (sel) begin
      exp_lat[0] = d[7:0]; exp_lat[1] = d[15:8]; exp_lat[2] = d[23:16];
      exp_empty = 1'b0; exp_irq++;
    end
  endtask

  task automatic host_read(input logic sel);
    @(negedge clk);
    host_cs_n = ~sel; host_oe_n = 1'b0;
    idle(4);
    chk("R5 drive", port_drive, sel);
    if (sel) chk("R5 dout", port_dout, {exp_lat[2], exp_lat[1], exp_lat[0]});
    host_oe_n = 1'b1;
    idle(4);
    chk("R5 drive off", port_drive, 1'b0);
    host_cs_n = 1'b1;
    idle(3);
    if (sel) begin exp_ready = 1'b0; exp_irq++; end
  endtask

  initial begin
    logic [7:0] r;
    void'($urandom(32'd20240611));
    exp_ready = 1'b0; exp_empty = 1'b1; prdy = 1'b0; pemp = 1'b0;
    for (int i = 0; i < 3; i++) exp_lat[i] = 8'h00;
    idle(5);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 ready_pin", ready_pin, 1'b0);
    chk("R1 empty_pin", empty_pin, 1'b1);
    chk("R1 drive", port_drive, 1'b0);
    chk("R1 irq", port_irq, 1'b0);
    check_state("R1");

    // multi-byte load, byte 0 last
    cpu_write(2'd2, 8'hC3);
    cpu_write(2'd1, 8'hB2);
    chk("R2 side bytes no ready", ready_pin, 1'b0);
    cpu_write(2'd0, 8'hA1);
    check_state("R2 arm");
    host_read(1'b1);
    check_state("R3 host read");
    chk("R7 irq after read", irq_seen, 1);

    // host write captures all bytes
    host_write(24'h5A6B7C, 1'b1);
    check_state("R4 host write");
    cpu_read(2'd2, r); chk("R6 byte2", r, 8'h5A);
    cpu_read(2'd1, r); chk("R6 byte1", r, 8'h6B);
    chk("R2 side read no empty", empty_pin, 1'b0);
    cpu_read(2'd0, r); chk("R6 byte0", r, 8'h7C);
    check_state("R4 arm");

    // deselected host traffic is ignored
    host_write(24'h112233, 1'b0);
    host_read(1'b0);
    cpu_read(2'd0, r); chk("R8 latch kept", r, 8'h7C);
    check_state("R8 deselected");

    // polarity swap
    cpu_write(2'd3, 8'h0C);
    check_state("R9 pol both");
    cpu_write(2'd3, 8'h04);
    check_state("R9 pol ready");

    // R10: arm while host holds output enable active
    @(negedge clk); host_cs_n = 1'b0; host_oe_n = 1'b0;
    idle(4);
    @(negedge clk); cpu_addr = 2'd0; cpu_wdata = 8'h99; cpu_wr = 1'b1;
    @(negedge clk); cpu_wr = 1'b0;
    chk("R10 arm wins ready", ready_pin, 1'b1 ^ prdy);
    @(negedge clk);
    chk("R3 level clear ready", ready_pin, 1'b0 ^ prdy);
    host_oe_n = 1'b1; idle(4); host_cs_n = 1'b1; idle(3);
    exp_lat[0] = 8'h99; exp_ready = 1'b0; exp_irq++;
    check_state("R10 ready");

    // R10: arm empty while host holds strobe active
    @(negedge clk); port_din = 24'h0F1E2D; host_cs_n = 1'b0; host_stb_n = 1'b0;
    idle(4);
    @(negedge clk); cpu_addr = 2'd0; cpu_rd = 1'b1;
    @(negedge clk); cpu_rd = 1'b0;
    chk("R10 arm wins empty", empty_pin, 1'b1 ^ pemp);
    chk("R6 read during strobe", cpu_rdata, 8'h2D);
    @(negedge clk);
    chk("R4 level clear empty", empty_pin, 1'b0 ^ pemp);
    host_stb_n = 1'b1; idle(4); host_cs_n = 1'b1; idle(3);
    exp_lat[0] = 8'h2D; exp_lat[1] = 8'h1E; exp_lat[2] = 8'h0F;
    exp_empty = 1'b0; exp_irq++;
    check_state("R10 empty");

    // constrained random mix
    for (int n = 0; n < 200; n++) begin
      int op;
      op = $urandom_range(0, 5);
      case (op)
        0: cpu_write(2'($urandom_range(0, 2)), 8'($urandom));
        1: begin
             logic [1:0] a;
             a = 2'($urandom_range(0, 2));
             cpu_read(a, r);
             chk("R6 random read", r, exp_lat[a]);
           end
        2: host_write(24'($urandom), 1'($urandom_range(0, 3) != 0));
        3: host_read(1'($urandom_range(0, 3) != 0));
        4: cpu_write(2'd3, {4'h0, 2'($urandom), 2'($urandom)});
        default: idle(2);
      endcase
      check_state("random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule